// File: doc/BRIEF.md
# Split-Mode Display Pixel FIFO

This block sits between a memory-fetching DMA engine and a display pixel datapath. It stores the words the DMA engine writes and hands them to the datapath whenever the panel timing logic strobes a data request. One storage array of `TOTAL_DEPTH` words (2048 by default) is used in one of two ways. For single-scan panels it is one deep queue. For dual-scan panels, which refresh an upper and a lower screen half at the same time, it is two independent queues of half the depth each.

Each queue keeps a registered fill count. Each queue also drives its own registered DMA request line, which stays high while the fill count is below a threshold set by software. In dual-scan mode a single data request takes one word from each half in the same cycle. A pop that cannot be served is refused. A write that finds its queue full is dropped. Each of these events sets a sticky flag. The scan mode can only be changed while both queues are empty, and a change also resets the queue pointers.

Top module: `pixbuf_split_fifo`

## Requirements
- R1: While `rst_n` is low, `fill_up`, `fill_lo`, `px_valid`, `ovf_flag`, `unf_flag`, `scan_dual` and both `dma_req` bits are 0. The block comes out of reset in single-scan mode.
- R2: In single-scan mode (`scan_dual`=0) the block is one first-in first-out queue of `TOTAL_DEPTH` words, counted on `fill_up`. `dma_wr_sel` has no effect in this mode, `fill_lo` stays 0, and `px_data_lo` is 0 on every popped word.
- R3: In dual-scan mode (`scan_dual`=1) there are two independent queues of `TOTAL_DEPTH/2` words each. A write with `dma_wr_sel`=0 goes to the upper queue (`fill_up`). A write with `dma_wr_sel`=1 goes to the lower queue (`fill_lo`).
- R4: A served `px_req` raises `px_valid` one cycle later. With it comes the oldest upper or single-queue word on `px_data_up`. In dual-scan mode the oldest lower word comes on `px_data_lo` in the same cycle.
- R5: A `px_req` is refused when the single queue is empty, or in dual-scan mode when either queue is empty. A refused request removes no word and gives no `px_valid`, and it sets the sticky `unf_flag` in the next cycle.
- R6: A write to a full queue is dropped and leaves the fill count unchanged. It sets the sticky `ovf_flag` in the next cycle.
- R7: A one-cycle `flag_clr` pulse clears both sticky flags in the next cycle. If a new event comes in the same cycle, the setting wins.
- R8: A write and a served pop in the same cycle on the same queue leave its fill count unchanged.
- R9: `dma_req[q]` is a register loaded every cycle with (fill count of queue q < `thresh`), so it follows a change of the count one cycle later. Any `thresh` value is accepted: 0 never requests. `dma_req[1]` is 0 whenever the block was in single-scan mode in the previous cycle.
- R10: A `cfg_apply` pulse loads `cfg_dual` into `scan_dual` in the next cycle only when both fill counts are 0, and it resets all pointers. Otherwise it has no effect. A write in the cycle of an accepted apply is dropped without setting `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | Requested scan mode, 1 = dual |
| cfg_apply | input | 1 | Pulse to take `cfg_dual` when both queues are empty |
| thresh | input | $clog2(TOTAL_DEPTH)+1 | DMA request threshold in words |
| dma_wr_en | input | 1 | DMA word write strobe |
| dma_wr_sel | input | 1 | Target half in dual mode: 0 upper, 1 lower |
| dma_wr_data | input | DW | DMA word |
| dma_req | output | 2 | Per-queue registered DMA request, bit 0 upper/single |
| px_req | input | 1 | Data request from the timing generator |
| px_valid | output | 1 | Popped data present this cycle |
| px_data_up | output | DW | Upper or single-queue word |
| px_data_lo | output | DW | Lower word (0 in single mode) |
| flag_clr | input | 1 | Pulse that clears the sticky flags |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| unf_flag | output | 1 | Sticky refused-pop flag |
| scan_dual | output | 1 | Current scan mode |
| fill_up | output | $clog2(TOTAL_DEPTH)+1 | Upper or single queue word count |
| fill_lo | output | $clog2(TOTAL_DEPTH)+1 | Lower queue word count |

## Verification
Fill counts, sticky flags and the scan mode are registered, so each one moves at the first rising edge after the stimulus. Popped data and `px_valid` appear at that same edge. The DMA request lines sit one register further on and change a full cycle after the count. The bench drives every input on a falling edge and reads results on the next falling edge. Before judging `dma_req` it inserts one idle cycle. A scoreboard queue holds the expected word pairs and is matched against each `px_valid` cycle, so any extra or missing pop is caught.

// File: rtl/pixbuf_pkg.sv
package pixbuf_pkg;
  typedef enum logic {
    SCAN_SINGLE = 1'b0,
    SCAN_DUAL   = 1'b1
  } scan_e;
endpackage

// File: rtl/pixbuf_bank.sv
// One storage half: synchronous write, registered read with enable.
module pixbuf_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pixbuf_qctrl.sv
// Pointer pair and registered occupancy counter for one queue.
module pixbuf_qctrl #(
  parameter int PW = 11,
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] last_idx,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [CW-1:0] count
);
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = (wptr_q == last_idx) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_d = (rptr_q == last_idx) ? '0 : rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign count = cnt_q;
endmodule

// File: rtl/pixbuf_reqgen.sv
// Registered threshold comparison driving one DMA request line.
module pixbuf_reqgen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] thresh,
  output logic          req
);
  logic req_q, req_d;

  always_comb req_d = en && (level < thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/pixbuf_split_fifo.sv
// Repartitionable pixel FIFO: one deep queue or two half-size queues.
module pixbuf_split_fifo
  import pixbuf_pkg::*;
#(
  parameter int DW          = 32,
  parameter int TOTAL_DEPTH = 2048,
  localparam int LW         = $clog2(TOTAL_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dual,
  input  logic          cfg_apply,
  input  logic [LW-1:0] thresh,
  input  logic          dma_wr_en,
  input  logic          dma_wr_sel,
  input  logic [DW-1:0] dma_wr_data,
  output logic [1:0]    dma_req,
  input  logic          px_req,
  output logic          px_valid,
  output logic [DW-1:0] px_data_up,
  output logic [DW-1:0] px_data_lo,
  input  logic          flag_clr,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          scan_dual,
  output logic [LW-1:0] fill_up,
  output logic [LW-1:0] fill_lo
);
  localparam int PW   = LW - 1;
  localparam int HALF = TOTAL_DEPTH / 2;
  localparam int HAW  = PW - 1;
  localparam logic [LW-1:0] CAP_ALL  = LW'(TOTAL_DEPTH);
  localparam logic [LW-1:0] CAP_HALF = LW'(HALF);
  localparam logic [PW-1:0] LAST_ALL  = PW'(TOTAL_DEPTH - 1);
  localparam logic [PW-1:0] LAST_HALF = PW'(HALF - 1);

  scan_e mode_q, mode_d;
  logic  dual;

  logic [PW-1:0]  wptr [2];
  logic [PW-1:0]  rptr [2];
  logic [LW-1:0]  cnt  [2];
  logic [PW-1:0]  last_idx [2];
  logic [1:0]     push, pop, req_en;

  logic [1:0]     bank_we, bank_re;
  logic [HAW-1:0] bank_waddr [2];
  logic [HAW-1:0] bank_raddr [2];
  logic [DW-1:0]  bank_rdata [2];

  logic apply_ok, tgt_lo, full_up, full_lo, wr_take, wr_drop, pop_ok, rd_miss;
  logic wtop, rtop;
  logic ovf_q, ovf_d, unf_q, unf_d;
  logic vld_q, vld_d, osel_q, osel_d, odual_q, odual_d;

  assign dual = (mode_q == SCAN_DUAL);

  // Push and pop decisions
  always_comb begin
    apply_ok = cfg_apply && (cnt[0] == '0) && (cnt[1] == '0);
    tgt_lo   = dual && dma_wr_sel;
    full_up  = (cnt[0] == (dual ? CAP_HALF : CAP_ALL));
    full_lo  = (cnt[1] == CAP_HALF);
    wr_take  = dma_wr_en && !apply_ok;
    push[0]  = wr_take && !tgt_lo && !full_up;
    push[1]  = wr_take &&  tgt_lo && !full_lo;
    wr_drop  = wr_take && (tgt_lo ? full_lo : full_up);
    pop_ok   = px_req && (cnt[0] != '0) && (!dual || (cnt[1] != '0));
    pop[0]   = pop_ok;
    pop[1]   = pop_ok && dual;
    rd_miss  = px_req && !pop_ok;
    mode_d   = mode_q;
    if (apply_ok) mode_d = cfg_dual ? SCAN_DUAL : SCAN_SINGLE;
    last_idx[0] = dual ? LAST_HALF : LAST_ALL;
    last_idx[1] = LAST_HALF;
    req_en[0]   = 1'b1;
    req_en[1]   = dual;
  end

  // Steering of queue pointers onto the two banks
  always_comb begin
    wtop = wptr[0][PW-1];
    rtop = rptr[0][PW-1];
    bank_we[0]    = dual ? push[0] : (push[0] && !wtop);
    bank_we[1]    = dual ? push[1] : (push[0] &&  wtop);
    bank_re[0]    = dual ? pop[0]  : (pop[0]  && !rtop);
    bank_re[1]    = dual ? pop[1]  : (pop[0]  &&  rtop);
    bank_waddr[0] = wptr[0][HAW-1:0];
    bank_waddr[1] = dual ? wptr[1][HAW-1:0] : wptr[0][HAW-1:0];
    bank_raddr[0] = rptr[0][HAW-1:0];
    bank_raddr[1] = dual ? rptr[1][HAW-1:0] : rptr[0][HAW-1:0];
  end

  // Flag and output-stage next state
  always_comb begin
    ovf_d   = wr_drop || (ovf_q && !flag_clr);
    unf_d   = rd_miss || (unf_q && !flag_clr);
    vld_d   = pop_ok;
    osel_d  = osel_q;
    odual_d = odual_q;
    if (pop_ok) begin
      osel_d  = dual ? 1'b0 : rtop;
      odual_d = dual;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= SCAN_SINGLE;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      vld_q   <= 1'b0;
      osel_q  <= 1'b0;
      odual_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
      vld_q   <= vld_d;
      osel_q  <= osel_d;
      odual_q <= odual_d;
    end
  end

  for (genvar q = 0; q < 2; q++) begin : g_lane
    pixbuf_qctrl #(.PW(PW)) i_qctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (apply_ok),
      .push     (push[q]),
      .pop      (pop[q]),
      .last_idx (last_idx[q]),
      .wptr     (wptr[q]),
      .rptr     (rptr[q]),
      .count    (cnt[q])
    );

    pixbuf_reqgen #(.CW(LW)) i_reqgen (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (req_en[q]),
      .level  (cnt[q]),
      .thresh (thresh),
      .req    (dma_req[q])
    );

    pixbuf_bank #(.DW(DW), .DEPTH(HALF)) i_bank (
      .clk     (clk),
      .wr_en   (bank_we[q]),
      .wr_addr (bank_waddr[q]),
      .wr_data (dma_wr_data),
      .rd_en   (bank_re[q]),
      .rd_addr (bank_raddr[q]),
      .rd_data (bank_rdata[q])
    );
  end

  assign px_valid   = vld_q;
  assign px_data_up = (odual_q || !osel_q) ? bank_rdata[0] : bank_rdata[1];
  assign px_data_lo = odual_q ? bank_rdata[1] : '0;
  assign ovf_flag   = ovf_q;
  assign unf_flag   = unf_q;
  assign scan_dual  = dual;
  assign fill_up    = cnt[0];
  assign fill_lo    = cnt[1];
endmodule

// File: rtl/pixbuf_split_fifo_chk.sv
module pixbuf_split_fifo_chk #(
  parameter int DW          = 32,
  parameter int TOTAL_DEPTH = 2048,
  localparam int LW         = $clog2(TOTAL_DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_apply,
  input logic [LW-1:0] thresh,
  input logic          dma_wr_en,
  input logic [1:0]    dma_req,
  input logic          px_req,
  input logic          px_valid,
  input logic          flag_clr,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          scan_dual,
  input logic [LW-1:0] fill_up,
  input logic [LW-1:0] fill_lo
);
  localparam logic [LW-1:0] CAP_ALL  = LW'(TOTAL_DEPTH);
  localparam logic [LW-1:0] CAP_HALF = LW'(TOTAL_DEPTH / 2);

  // R2
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_up <= (scan_dual ? CAP_HALF : CAP_ALL)) && (fill_lo <= CAP_HALF));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_req && fill_up == '0) |=> (!px_valid && unf_flag));

  // R9
  req_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dma_req[0] == ($past(fill_up) < $past(thresh))));

  // R9
  lo_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_dual |=> !dma_req[1]);

  // R8
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_dual && !cfg_apply && dma_wr_en && px_req &&
     fill_up != '0 && fill_up != CAP_ALL) |=> $stable(fill_up));

  // R10
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_apply && (fill_up != '0 || fill_lo != '0)) |=> $stable(scan_dual));

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_dual && !cfg_apply && dma_wr_en && !px_req && fill_up == CAP_ALL)
      |=> (fill_up == CAP_ALL && ovf_flag));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !dma_wr_en && !px_req) |=> (!ovf_flag && !unf_flag));
endmodule

bind pixbuf_split_fifo pixbuf_split_fifo_chk #(
  .DW(DW), .TOTAL_DEPTH(TOTAL_DEPTH)
) i_chk (.*);

// File: tb/test_pixbuf_split_fifo.sv
`timescale 1ns/1ps
module test_pixbuf_split_fifo;
  localparam int DW = 32;
  localparam int TD = 2048;
  localparam int HD = TD / 2;
  localparam int LW = $clog2(TD) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0, cfg_apply = 1'b0;
  logic [LW-1:0] thresh = LW'(16);
  logic dma_wr_en = 1'b0, dma_wr_sel = 1'b0;
  logic [DW-1:0] dma_wr_data = '0;
  logic [1:0] dma_req;
  logic px_req = 1'b0, px_valid;
  logic [DW-1:0] px_data_up, px_data_lo;
  logic flag_clr = 1'b0, ovf_flag, unf_flag, scan_dual;
  logic [LW-1:0] fill_up, fill_lo;

  always #2.5 clk = ~clk;

  pixbuf_split_fifo #(.DW(DW), .TOTAL_DEPTH(TD)) i_pixbuf_split_fifo (.*);

  int checks = 0, errs = 0;
  bit done = 1'b0;
  bit m_dual = 1'b0;
  logic [DW-1:0] mq_up[$], mq_lo[$], exp_up[$], exp_lo[$];
  logic [DW-1:0] seed = 32'h1000_0000;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every valid pop is matched against the expected queue
  always @(negedge clk) begin
    if (rst_n && px_valid) begin
      if (exp_up.size() == 0) begin
        checks++; errs++;
        $display("FAIL R4 unexpected px_valid: actual 1 expected 0");
      end else begin
        logic [DW-1:0] eu, el;
        eu = exp_up.pop_front();
        el = exp_lo.pop_front();
        chk("R4", "px_data_up", px_data_up, eu);
        chk("R2/R3", "px_data_lo", px_data_lo, el);
      end
    end
  end

  // Driver: one cycle of write and/or pop, model updated from pre-cycle state
  task automatic step(bit we, bit sel, bit re);
    int s_up, s_lo, cap_up;
    bit pok, tlo;
    logic [DW-1:0] d;
    d = seed; seed = seed + 1;
    dma_wr_en = we; dma_wr_sel = sel; dma_wr_data = d; px_req = re;
    s_up = mq_up.size(); s_lo = mq_lo.size();
    cap_up = m_dual ? HD : TD;
    pok = re && s_up > 0 && (!m_dual || s_lo > 0);
    if (pok) begin
      exp_up.push_back(mq_up.pop_front());
      exp_lo.push_back(m_dual ? mq_lo.pop_front() : '0);
    end
    tlo = m_dual && sel;
    if (we) begin
      if (tlo && s_lo < HD) mq_lo.push_back(d);
      else if (!tlo && s_up < cap_up) mq_up.push_back(d);
    end
    @(negedge clk);
    dma_wr_en = 1'b0; px_req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic apply_mode(bit d, bit with_wr);
    cfg_dual = d; cfg_apply = 1'b1;
    dma_wr_en = with_wr; dma_wr_sel = 1'b0; dma_wr_data = 32'hDEAD_0001;
    if (mq_up.size() == 0 && mq_lo.size() == 0) m_dual = d;
    @(negedge clk);
    cfg_apply = 1'b0; dma_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL all watchdog expired: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1", "fill_up", fill_up, 0);
    chk("R1", "fill_lo", fill_lo, 0);
    chk("R1", "px_valid", px_valid, 0);
    chk("R1", "flags", {ovf_flag, unf_flag}, 0);
    chk("R1", "scan_dual", scan_dual, 0);
    chk("R1", "dma_req", dma_req, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R9", "req after reset", dma_req, 2'b01);

    // R9 threshold crossing seen one cycle after the count
    thresh = LW'(3);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    chk("R9", "fill_up at 3", fill_up, 3);
    chk("R9", "req still high", dma_req[0], 1);
    idle(1);
    chk("R9", "req dropped", dma_req[0], 0);

    // R8 simultaneous push and pop
    step(1, 0, 1);
    chk("R8", "fill_up held", fill_up, 3);
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    chk("R2", "drained", fill_up, 0);

    // R2 select ignored in single mode
    step(1, 1, 0);
    step(1, 1, 0);
    chk("R2", "fill_up with sel", fill_up, 2);
    chk("R2", "fill_lo stays 0", fill_lo, 0);
    step(0, 0, 1);
    step(0, 0, 1);

    // R5 underflow on empty single queue, R7 clear
    step(0, 0, 1);
    chk("R5", "no valid on empty", px_valid, 0);
    chk("R5", "unf_flag", unf_flag, 1);
    clear_flags();
    chk("R7", "unf cleared", unf_flag, 0);

    // R6 full single queue, thresh 0 never requests
    thresh = '0;
    for (int i = 0; i < TD; i++) step(1, 0, 0);
    chk("R2", "fill_up full", fill_up, TD);
    chk("R9", "thresh 0 no req", dma_req, 0);
    step(1, 0, 0);
    chk("R6", "fill_up unchanged", fill_up, TD);
    chk("R6", "ovf_flag", ovf_flag, 1);
    apply_mode(1'b1, 1'b0);
    chk("R10", "mode locked", scan_dual, 0);
    for (int i = 0; i < TD; i++) step(0, 0, 1);
    chk("R2", "drained full", fill_up, 0);
    clear_flags();
    chk("R7", "ovf cleared", ovf_flag, 0);

    // R10 accepted change, write in that cycle dropped
    apply_mode(1'b1, 1'b1);
    chk("R10", "dual taken", scan_dual, 1);
    chk("R10", "write dropped", fill_up, 0);
    chk("R10", "no ovf", ovf_flag, 0);

    // R3 dual queues, R9 per-queue request
    thresh = LW'(2);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(1, 1, 0);
    chk("R3", "fill_up", fill_up, 3);
    chk("R3", "fill_lo", fill_lo, 1);
    idle(1);
    chk("R9", "dual req", dma_req, 2'b10);
    step(0, 0, 1);
    step(0, 0, 1);
    chk("R5", "dual refused", px_valid, 0);
    chk("R5", "dual unf", unf_flag, 1);
    chk("R5", "upper kept", fill_up, 2);
    clear_flags();
    step(1, 1, 0);
    step(1, 1, 0);
    step(0, 0, 1);
    step(0, 0, 1);
    chk("R3", "dual drained", fill_up + fill_lo, 0);

    // R6 per-half overflow in dual mode
    for (int i = 0; i < HD; i++) step(1, 0, 0);
    step(1, 0, 0);
    chk("R6", "upper full", fill_up, HD);
    chk("R6", "dual ovf", ovf_flag, 1);
    chk("R3", "lower untouched", fill_lo, 0);
    for (int i = 0; i < HD; i++) step(1, 1, 0);
    for (int i = 0; i < HD; i++) step(0, 0, 1);
    chk("R3", "pairs drained", fill_up + fill_lo, 0);
    clear_flags();

    // Back to single mode
    apply_mode(1'b0, 1'b0);
    chk("R10", "single taken", scan_dual, 0);
    idle(2);
    chk("R9", "lower req idle", dma_req[1], 0);
    idle(2);
    chk("R4", "scoreboard empty", exp_up.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule